// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout

A register-mapped watchdog with two down counters. The main counter guards the system: if software does not rewrite its count before it runs out, the block raises an expiry interrupt and, when permitted, a reset request. The second counter is loaded with a shorter count. It expires first and raises an early-warning interrupt, so software has time to react before the main counter runs out.

Each counter steps either on a tick from a shared power-of-two prescaler of the system clock or on a pulse from an external fixed-rate reference. The reference arrives as a one-cycle tick input that is already synchronous to the system clock. A keepalive is a plain write to a count register. The reset request passes through two gates: an enable bit in one register and a mask bit in another.

Top module: `wdog_pretimeout`

## Requirements
- R1: After reset both count registers read 0xFFFFFFFF. Control, status, reset-enable and reset-mask read 0, and all three outputs are low.
- R2: A write to offset 0x34 (main) or 0x1C (early-warning) loads that counter on the write edge, and a read of the same offset returns the remaining count.
- R3: With its fixed-select bit clear, an enabled counter decrements once every 2^e system cycles, where e is control bits [18:16]. Outside a reload, a count never increases.
- R4: Control bit 10 (main) or bit 12 (early-warning) makes that counter step only on ref_tick_i pulses. Prescaler ticks then have no effect on it.
- R5: When the main counter steps from 1 to 0, status bit 31 (offset 0x04) sets and wd_irq_o is high for exactly one cycle. The counter then holds at 0.
- R6: Control bit 2 enables the early-warning counter. Its step to 0 sets status bit 8 and pulses pre_irq_o for one cycle, and it reaches zero before a longer main count does.
- R7: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged.
- R8: With its enable bit clear (control bit 8 for the main counter), a counter keeps its value and raises no expiry.
- R9: rst_req_o rises with a main expiry only if bit 8 of the reset-enable register (offset 0x40) is 1 and bit 10 of the reset-mask register (offset 0x44) is 0. It then stays high until status bit 31 is cleared.
- R10: Reads of undefined offsets return 0. Control reads back only bits 2, 8, 10, 12 and [18:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse from the fixed-rate reference |
| addr_i | input | ADDR_W | Byte offset of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| wd_irq_o | output | 1 | Main counter expiry pulse |
| pre_irq_o | output | 1 | Early-warning expiry pulse |
| rst_req_o | output | 1 | Reset request level |

## Verification
The rate check sweeps prescaler exponents 0 to 3 and 5, with windows of one to three tick periods. An exact remaining count shows that each window holds exactly one step per period, so both off-by-one phasing and a wrong divide ratio are caught. The fixed-select cases mix reference pulses with running prescaler ticks, so a count that follows the wrong source is visible. The expiry and gating cases compare the enable-only, masked and disabled combinations against the cycle-exact edges of the interrupts and the reset request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFF_CTRL     = 'h00;
  localparam int OFF_STAT     = 'h04;
  localparam int OFF_PRE_CNT  = 'h1C;
  localparam int OFF_WD_CNT   = 'h34;
  localparam int OFF_RST_EN   = 'h40;
  localparam int OFF_RST_MASK = 'h44;

  localparam int B_PRE_EN   = 2;
  localparam int B_WD_EN    = 8;
  localparam int B_WD_FIX   = 10;
  localparam int B_PRE_FIX  = 12;
  localparam int EXP_LSB    = 16;
  localparam int EXP_W      = 3;
  localparam int B_ST_WD    = 31;
  localparam int B_ST_PRE   = 8;
  localparam int B_RST_EN   = 8;
  localparam int B_RST_MASK = 10;

  localparam int CNT_WD  = 0;
  localparam int CNT_PRE = 1;

  typedef struct packed {
    logic             wd_en;
    logic             pre_en;
    logic             wd_fix;
    logic             pre_fix;
    logic [EXP_W-1:0] expo;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // low exp_i bits all ones: one tick every 2^exp cycles
  always_comb begin
    mask   = ~({DIV_W{1'b1}} << exp_i);
    tick_o = &(div_q | ~mask);
  end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fix_i,
  input  logic             sys_tick_i,
  input  logic             ref_tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             tick;
  logic             step;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    tick     = fix_i ? ref_tick_i : sys_tick_i;
    step     = !load_i && en_i && tick && (cnt_q != '0);
    expire_o = step && (cnt_q == ONE);
    cnt_o    = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/wdog_pretimeout.sv
module wdog_pretimeout
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              wd_irq_o,
  output logic              pre_irq_o,
  output logic              rst_req_o
);
  localparam int NCNT = 2;

  ctrl_t                        ctrl_q;
  logic                         rst_en_q;
  logic                         rst_mask_q;
  logic [NCNT-1:0]              flag_q, flag_d, clr, evt;
  logic [NCNT-1:0]              en_vec, fix_vec, load_vec;
  logic [NCNT-1:0][CNT_W-1:0]   cnt_vec;
  logic [NCNT-1:0]              irq_q;
  logic                         rst_req_q, rst_req_d;
  logic                         sys_tick;
  logic                         wr_ctrl, wr_stat, wr_ren, wr_rmask;

  always_comb begin
    wr_ctrl  = we_i && (addr_i == ADDR_W'(OFF_CTRL));
    wr_stat  = we_i && (addr_i == ADDR_W'(OFF_STAT));
    wr_ren   = we_i && (addr_i == ADDR_W'(OFF_RST_EN));
    wr_rmask = we_i && (addr_i == ADDR_W'(OFF_RST_MASK));
    load_vec[CNT_WD]  = we_i && (addr_i == ADDR_W'(OFF_WD_CNT));
    load_vec[CNT_PRE] = we_i && (addr_i == ADDR_W'(OFF_PRE_CNT));
    en_vec[CNT_WD]    = ctrl_q.wd_en;
    en_vec[CNT_PRE]   = ctrl_q.pre_en;
    fix_vec[CNT_WD]   = ctrl_q.wd_fix;
    fix_vec[CNT_PRE]  = ctrl_q.pre_fix;
  end

  wdog_prescaler #(.EXP_W(EXP_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exp_i  (ctrl_q.expo),
    .tick_o (sys_tick)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_vec[i]),
      .fix_i      (fix_vec[i]),
      .sys_tick_i (sys_tick),
      .ref_tick_i (ref_tick_i),
      .load_i     (load_vec[i]),
      .load_val_i (wdata_i[CNT_W-1:0]),
      .cnt_o      (cnt_vec[i]),
      .expire_o   (evt[i])
    );
  end

  // write-0-to-clear; a new expiry wins over a clear in the same cycle
  always_comb begin
    clr[CNT_WD]  = wr_stat && !wdata_i[B_ST_WD];
    clr[CNT_PRE] = wr_stat && !wdata_i[B_ST_PRE];
    flag_d       = evt | (flag_q & ~clr);
    rst_req_d    = (evt[CNT_WD] && rst_en_q && !rst_mask_q)
                 || (rst_req_q && flag_d[CNT_WD]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      rst_en_q   <= 1'b0;
      rst_mask_q <= 1'b0;
      flag_q     <= '0;
      irq_q      <= '0;
      rst_req_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.wd_en   <= wdata_i[B_WD_EN];
        ctrl_q.pre_en  <= wdata_i[B_PRE_EN];
        ctrl_q.wd_fix  <= wdata_i[B_WD_FIX];
        ctrl_q.pre_fix <= wdata_i[B_PRE_FIX];
        ctrl_q.expo    <= wdata_i[EXP_LSB +: EXP_W];
      end
      if (wr_ren)   rst_en_q   <= wdata_i[B_RST_EN];
      if (wr_rmask) rst_mask_q <= wdata_i[B_RST_MASK];
      flag_q    <= flag_d;
      irq_q     <= evt;
      rst_req_q <= rst_req_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL)) begin
      rdata_o[B_WD_EN]             = ctrl_q.wd_en;
      rdata_o[B_PRE_EN]            = ctrl_q.pre_en;
      rdata_o[B_WD_FIX]            = ctrl_q.wd_fix;
      rdata_o[B_PRE_FIX]           = ctrl_q.pre_fix;
      rdata_o[EXP_LSB +: EXP_W]    = ctrl_q.expo;
    end else if (addr_i == ADDR_W'(OFF_STAT)) begin
      rdata_o[B_ST_WD]  = flag_q[CNT_WD];
      rdata_o[B_ST_PRE] = flag_q[CNT_PRE];
    end else if (addr_i == ADDR_W'(OFF_WD_CNT)) begin
      rdata_o[CNT_W-1:0] = cnt_vec[CNT_WD];
    end else if (addr_i == ADDR_W'(OFF_PRE_CNT)) begin
      rdata_o[CNT_W-1:0] = cnt_vec[CNT_PRE];
    end else if (addr_i == ADDR_W'(OFF_RST_EN)) begin
      rdata_o[B_RST_EN] = rst_en_q;
    end else if (addr_i == ADDR_W'(OFF_RST_MASK)) begin
      rdata_o[B_RST_MASK] = rst_mask_q;
    end
  end

  assign wd_irq_o  = irq_q[CNT_WD];
  assign pre_irq_o = irq_q[CNT_PRE];
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wd_irq_i,
  input logic             pre_irq_i,
  input logic             rst_req_i,
  input logic             wd_flag_i,
  input logic             wd_en_i,
  input logic             wd_load_i,
  input logic [CNT_W-1:0] wd_cnt_i
);
  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_irq_i |=> !wd_irq_i);

  a_r6_pre_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_irq_i |=> !pre_irq_i);

  a_r5_irq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_irq_i |-> wd_flag_i);

  a_r9_req_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> wd_flag_i);

  a_r9_req_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_i) |-> wd_irq_i);

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_en_i && !wd_load_i) |=> $stable(wd_cnt_i));

  a_r3_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_load_i |=> (wd_cnt_i <= $past(wd_cnt_i)));
endmodule

bind wdog_pretimeout wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wd_irq_i  (wd_irq_o),
  .pre_irq_i (pre_irq_o),
  .rst_req_i (rst_req_o),
  .wd_flag_i (flag_q[0]),
  .wd_en_i   (en_vec[0]),
  .wd_load_i (load_vec[0]),
  .wd_cnt_i  (cnt_vec[0])
);

// File: tb/sim_wdog_pretimeout.sv
`timescale 1ns/1ps
module sim_wdog_pretimeout;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wd_irq, pre_irq, rst_req;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  wdog_pretimeout u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .wd_irq_o(wd_irq), .pre_irq_o(pre_irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_pulse();
    ref_tick = 1'b1; cyc(1); ref_tick = 1'b0; cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL run timeout act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);

    // R1 reset state
    rd('h34, v); chk("R1 wd count", v, 32'hFFFF_FFFF);
    rd('h1C, v); chk("R1 pre count", v, 32'hFFFF_FFFF);
    rd('h00, v); chk("R1 ctrl", v, 0);
    rd('h04, v); chk("R1 status", v, 0);
    rd('h40, v); chk("R1 rst en", v, 0);
    chk("R1 outputs", {29'd0, wd_irq, pre_irq, rst_req}, 0);

    // R2 reload and readback with counter disabled
    wr('h34, 32'h1234_5678);
    rd('h34, v); chk("R2 wd load", v, 32'h1234_5678);
    wr('h1C, 32'h0000_0ABC);
    rd('h1C, v); chk("R2 pre load", v, 32'h0000_0ABC);

    // R3 prescaler sweep: k periods of 2^e cycles -> k steps
    for (int e = 0; e < 6; e++) begin
      if (e == 4) continue;
      for (int k = 1; k < 4; k++) begin
        wr('h00, (e << 16) | 32'h100);
        wr('h34, 32'd1000);
        cyc(k << e);
        rd('h34, v); chk($sformatf("R3 exp=%0d k=%0d", e, k), v, 32'd1000 - k);
      end
    end
    rd('h1C, v); chk("R8 pre frozen while disabled", v, 32'h0000_0ABC);

    // R4 fixed reference for main counter
    wr('h00, 32'h500);
    wr('h34, 32'd50);
    cyc(3);
    rd('h34, v); chk("R4 wd ignores prescaler", v, 32'd50);
    for (int i = 0; i < 7; i++) ref_pulse();
    rd('h34, v); chk("R4 wd ref steps", v, 32'd43);
    // R4 fixed reference for early-warning counter
    wr('h00, 32'h1004);
    wr('h1C, 32'd9);
    cyc(3);
    rd('h1C, v); chk("R4 pre ignores prescaler", v, 32'd9);
    for (int i = 0; i < 4; i++) ref_pulse();
    rd('h1C, v); chk("R4 pre ref steps", v, 32'd5);

    // R5 main expiry
    wr('h00, 32'h100);
    wr('h34, 32'd5);
    cyc(4);
    rd('h34, v); chk("R5 count before zero", v, 32'd1);
    chk("R5 irq low before zero", {31'd0, wd_irq}, 0);
    cyc(1);
    chk("R5 irq pulse", {31'd0, wd_irq}, 1);
    rd('h34, v); chk("R5 count zero", v, 0);
    rd('h04, v); chk("R5 status set", v, 32'h8000_0000);
    chk("R9 no req without enable", {31'd0, rst_req}, 0);
    cyc(1);
    chk("R5 irq one cycle", {31'd0, wd_irq}, 0);
    cyc(5);
    rd('h34, v); chk("R5 holds zero", v, 0);

    // R7 status clear semantics
    wr('h04, 32'hFFFF_FFFF);
    rd('h04, v); chk("R7 write 1 keeps", v, 32'h8000_0000);
    wr('h04, 32'h0);
    rd('h04, v); chk("R7 write 0 clears", v, 0);

    // R6 early warning precedes main expiry
    wr('h00, 32'h104);
    wr('h34, 32'd10);
    wr('h1C, 32'd4);
    cyc(4);
    chk("R6 pre irq", {31'd0, pre_irq}, 1);
    chk("R6 main not yet", {31'd0, wd_irq}, 0);
    rd('h34, v); chk("R6 main remaining", v, 32'd5);
    rd('h04, v); chk("R6 pre flag", v, 32'h0000_0100);
    cyc(1);
    chk("R6 pre irq one cycle", {31'd0, pre_irq}, 0);
    cyc(4);
    chk("R6 main expires later", {31'd0, wd_irq}, 1);
    rd('h04, v); chk("R6 both flags", v, 32'h8000_0100);
    wr('h04, 32'h8000_0000);
    rd('h04, v); chk("R7 clear pre only", v, 32'h8000_0000);
    wr('h04, 32'h0);

    // R8 freeze
    wr('h00, 32'h0);
    wr('h34, 32'd20);
    cyc(30);
    rd('h34, v); chk("R8 disabled holds", v, 32'd20);
    wr('h00, 32'h100);
    wr('h34, 32'd20);
    cyc(5);
    wr('h00, 32'h0);
    cyc(10);
    rd('h34, v); chk("R8 frozen mid-run", v, 32'd14);
    wr('h34, 32'd1);
    cyc(5);
    rd('h04, v); chk("R8 no expiry when off", v, 0);

    // R9 reset request gating
    wr('h40, 32'h100);
    wr('h44, 32'h0);
    wr('h00, 32'h100);
    wr('h34, 32'd3);
    cyc(2);
    chk("R9 req low before expiry", {31'd0, rst_req}, 0);
    cyc(1);
    chk("R9 req with expiry", {31'd0, rst_req}, 1);
    cyc(5);
    chk("R9 req held", {31'd0, rst_req}, 1);
    wr('h04, 32'h0);
    chk("R9 req drops on clear", {31'd0, rst_req}, 0);
    wr('h44, 32'h400);
    wr('h34, 32'd2);
    cyc(3);
    rd('h04, v); chk("R9 masked flag set", v, 32'h8000_0000);
    chk("R9 masked no req", {31'd0, rst_req}, 0);
    wr('h04, 32'h0);

    // R10 readback and undefined offsets
    rd('h08, v); chk("R10 undefined zero", v, 0);
    rd('h30, v); chk("R10 undefined zero 2", v, 0);
    rd('h40, v); chk("R10 rst en readback", v, 32'h100);
    rd('h44, v); chk("R10 rst mask readback", v, 32'h400);
    wr('h00, 32'hFFFF_FFFF);
    rd('h00, v); chk("R10 ctrl defined bits", v, 32'h0007_1504);
    wr('h00, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule